// File: doc/BRIEF.md
# Edge Capture Interrupt Unit

This unit watches 24 digital input lines and latches edges on them. Each line has its own enable bit and its own polarity bit. A polarity of 1 selects the rising edge and a polarity of 0 selects the falling edge. The register bank supplies the enable and polarity words as plain level inputs. When an enabled line shows an edge of the chosen direction, the line's bit in a 24-bit capture word is set. That bit stays set until software clears it.

Software clears captured bits through per-byte write strobes. Within a strobed byte, a data bit of 0 clears the matching capture bit and a data bit of 1 leaves it unchanged. The unit folds the capture word into a three-bit pending summary, with one bit per byte of eight lines. An active-high interrupt request is raised while any pending bit is set. Pin levels pass through a two-stage synchronizer, and an edge is found by comparing the synchronized level with its value one clock earlier.

Top module: `edge_capture_unit`

## Requirements
- R1: With polarity bit 1 and enable bit 1, a low-to-high transition on a line sets that line's capture bit; a high-to-low transition on the same line sets nothing.
- R2: With polarity bit 0 and enable bit 1, a high-to-low transition sets the line's capture bit; a low-to-high transition sets nothing.
- R3: A line whose enable bit is 0 never sets its capture bit, whatever its pin does; with all enable bits 0 the capture word gains no new bits.
- R4: A set capture bit stays set over any number of cycles until a clearing write reaches it.
- R5: A write with strobe bit g (g = 0..2, covering capture bits 8g..8g+7) clears each capture bit of that byte whose data bit is 0 and keeps those whose data bit is 1; bytes whose strobe is 0 are untouched. The clear is visible the cycle after the write.
- R6: When an edge on a line is detected in the same cycle that a write clears that line's bit, the bit ends set.
- R7: Pending bit g is 1 exactly when any capture bit 8g..8g+7 is 1.
- R8: The interrupt request is 1 exactly when any pending bit is 1.
- R9: Changing a polarity bit while the pin is steady, high or low, never sets the capture bit.
- R10: After reset the capture word, the pending bits and the interrupt request are all 0.
- R11: A pin transition, applied just after a clock edge, shows in the capture word after the third following rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 24 | Raw line levels |
| pol_i | input | 24 | Per-line edge polarity, 1 = rising |
| en_i | input | 24 | Per-line capture enable |
| id_wr_i | input | 3 | Per-byte clear strobes for the capture word |
| id_wdata_i | input | 24 | Write data, 0 clears a bit in a strobed byte |
| id_o | output | 24 | Capture word readback |
| pend_o | output | 3 | Per-byte pending summary |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A freshly detected edge and a software clear can land on the same capture bit in one clock. The bench provokes this by raising a pin and timing a byte-clear write so that the write reaches the third rising edge after the pin change. That is the edge at which the edge reaches the capture word. The write also targets a bit that was captured earlier in the same byte. The result passes only if the new edge's bit survives while the older bit of that byte is cleared.

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int NLINES      = 24,
  parameter int GROUPW      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NGROUP     = NLINES / GROUPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_i,
  input  logic [NLINES-1:0] pol_i,
  input  logic [NLINES-1:0] en_i,
  input  logic [NGROUP-1:0] id_wr_i,
  input  logic [NLINES-1:0] id_wdata_i,
  output logic [NLINES-1:0] id_o,
  output logic [NGROUP-1:0] pend_o,
  output logic              irq_o
);

  logic [SYNC_STAGES-1:0][NLINES-1:0] sync_q;
  logic [NLINES-1:0] prev_q, level, hit, clr, id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= level;
    end
  end

  assign level = sync_q[SYNC_STAGES-1];
  assign hit   = en_i & ((level & ~prev_q & pol_i) | (~level & prev_q & ~pol_i));

  for (genvar g = 0; g < NGROUP; g++) begin : g_byte
    assign clr[g*GROUPW +: GROUPW] = {GROUPW{id_wr_i[g]}} & ~id_wdata_i[g*GROUPW +: GROUPW];
    assign pend_o[g]               = |id_q[g*GROUPW +: GROUPW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else        id_q <= (id_q & ~clr) | hit;
  end

  assign id_o  = id_q;
  assign irq_o = |pend_o;

endmodule

module edge_capture_unit_chk #(
  parameter int NLINES = 24,
  parameter int NGROUP = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] en_i,
  input logic [NGROUP-1:0] id_wr_i,
  input logic [NLINES-1:0] id_o,
  input logic [NGROUP-1:0] pend_o,
  input logic              irq_o
);

  // R3
  new_bit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_o & ~$past(id_o) & ~$past(en_i)) == '0));

  // R4
  sticky_until_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(id_o) & ~id_o) != '0) |-> ($past(id_wr_i) != '0)));

  // R7
  pend_covers_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == '0) |-> (id_o == '0));

  // R8
  irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (id_o != '0));

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (id_o == '0 && !irq_o));

endmodule

bind edge_capture_unit edge_capture_unit_chk #(.NLINES(NLINES), .NGROUP(NGROUP)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .id_wr_i(id_wr_i),
  .id_o(id_o), .pend_o(pend_o), .irq_o(irq_o)
);

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin_i = '0, pol_i = '0, en_i = '0, id_wdata_i = '0;
  logic [2:0]  id_wr_i = '0;
  logic [23:0] id_o;
  logic [2:0]  pend_o;
  logic        irq_o;
  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pol_i(pol_i), .en_i(en_i),
    .id_wr_i(id_wr_i), .id_wdata_i(id_wdata_i),
    .id_o(id_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    id_wr_i = 3'b111; id_wdata_i = '0;
    step(1);
    id_wr_i = '0;
  endtask

  task automatic t_reset();
    check("R10 id", id_o, 24'h0);
    check("R10 pend", {21'b0, pend_o}, 24'h0);
    check("R10 irq", {23'b0, irq_o}, 24'h0);
  endtask

  task automatic t_rise();
    en_i = '1; pol_i = '1;
    pin_i[1] = 1'b1;
    step(2);
    check("R11 not yet", id_o, 24'h0);
    step(1);
    check("R1 R11 rise", id_o, 24'h000002);
    check("R7 pend", {21'b0, pend_o}, 24'h1);
    check("R8 irq", {23'b0, irq_o}, 24'h1);
    clear_all();
    check("R5 clear", id_o, 24'h0);
    check("R8 irq low", {23'b0, irq_o}, 24'h0);
    pin_i[1] = 1'b0;
    step(4);
    check("R1 fall ignored", id_o, 24'h0);
  endtask

  task automatic t_fall();
    pol_i[10] = 1'b0;
    pin_i[10] = 1'b1;
    step(4);
    check("R2 rise ignored", id_o, 24'h0);
    pin_i[10] = 1'b0;
    step(4);
    check("R2 fall", id_o, 24'h000400);
    check("R7 pend byte1", {21'b0, pend_o}, 24'h2);
    clear_all();
    pol_i[10] = 1'b1;
  endtask

  task automatic t_disabled();
    en_i[17] = 1'b0;
    pin_i[17] = 1'b1; step(4);
    pin_i[17] = 1'b0; step(4);
    check("R3 line off", id_o, 24'h0);
    en_i = '0;
    pin_i = 24'hA5A5A5; step(4);
    pin_i = '0; step(4);
    check("R3 all off", id_o, 24'h0);
    en_i = '1;
  endtask

  task automatic t_sticky();
    pin_i[20] = 1'b1; step(4);
    pin_i[20] = 1'b0;
    step(12);
    check("R4 sticky", id_o, 24'h100000);
    id_wr_i = 3'b100; id_wdata_i = '1; step(1); id_wr_i = '0;
    check("R5 ones keep", id_o, 24'h100000);
    id_wr_i = 3'b001; id_wdata_i = '0; step(1); id_wr_i = '0;
    check("R5 other byte", id_o, 24'h100000);
    id_wr_i = 3'b100; id_wdata_i = ~24'h100000; step(1); id_wr_i = '0;
    check("R5 zero clears", id_o, 24'h0);
    check("R7 pend clear", {21'b0, pend_o}, 24'h0);
  endtask

  task automatic t_polchange();
    for (int i = 0; i < 4; i++) begin
      pol_i[4] = ~pol_i[4]; step(2);
    end
    check("R9 low steady", id_o, 24'h0);
    pol_i[4] = 1'b1;
    pin_i[4] = 1'b1; step(4);
    clear_all();
    for (int i = 0; i < 4; i++) begin
      pol_i[4] = ~pol_i[4]; step(2);
    end
    check("R9 high steady", id_o, 24'h0);
    pol_i[4] = 1'b1;
    pin_i[4] = 1'b0; step(4);
    check("R9 fall with rise pol", id_o, 24'h0);
  endtask

  task automatic t_collision();
    pin_i[3] = 1'b1; step(4);
    check("R6 setup", id_o, 24'h000008);
    pin_i[5] = 1'b1;
    step(2);
    id_wr_i = 3'b001; id_wdata_i = '0;
    step(1);
    id_wr_i = '0;
    check("R6 edge wins", id_o, 24'h000020);
    clear_all();
    pin_i[3] = 1'b0; pin_i[5] = 1'b0; step(4);
    check("R6 tidy", id_o, 24'h0);
  endtask

  task automatic t_multi();
    pin_i[0] = 1'b1; pin_i[9] = 1'b1; pin_i[23] = 1'b1;
    step(4);
    check("R1 multi", id_o, 24'h800201);
    check("R7 all pend", {21'b0, pend_o}, 24'h7);
    id_wr_i = 3'b010; id_wdata_i = '0; step(1); id_wr_i = '0;
    check("R7 partial pend", {21'b0, pend_o}, 24'h5);
    check("R8 irq held", {23'b0, irq_o}, 24'h1);
    clear_all();
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_rise();
    t_fall();
    t_disabled();
    t_sticky();
    t_polchange();
    t_collision();
    t_multi();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule